// File: doc/BRIEF.md
# Teletext Bit Window Sequencer

This block decides on which video lines a serial teletext stream is inserted, and it paces the capture of that stream. It works on the 27 MHz line-locked sample clock. At each line start it latches whether the current line falls inside a programmable line range. Each of the two fields has its own range. On a selected line, a request output rises at a programmable horizontal position. This tells the external text source to start sending bits. A programmable lead time lets the source's latency settle before bit capture begins.

During the window, a modulo-144 phase accumulator advances by 37 on every clock. This sets a bit rate of 37/144 of the sample clock, which is about 6.94 Mbit/s. Each wrap of the accumulator marks a bit boundary, so every bit occupies three or four clocks. On each boundary the serial input is sampled and passed on as a bit plus a one-cycle valid strobe, for a downstream waveform shaper. The window closes after exactly 360 bits, clock run-in included. A programmable stop position can cut the window short.

Top module: `ttx_inserter`

## Requirements
- R1: While reset is active and on the first cycle after it, `ttx_req`, `tt_valid` and `tt_bit` are 0.
- R2: A line is selected when `line_num`, sampled in the cycle `line_start` is 1, satisfies first <= line_num <= last for the field named by `field_id` (0 uses `f0_first`/`f0_last`, 1 uses `f1_first`/`f1_last`). A range with first > last selects no line.
- R3: On a selected line with no window open, `ttx_req` rises in the cycle after the cycle where `hpos` equals `req_on_h`. It stays 1 until the window ends.
- R4: The first `tt_valid` pulse of a window appears `lead_clks` + 6 cycles after the cycle in which `hpos` equalled `req_on_h`.
- R5: Bit boundaries follow an accumulator that starts at 0 when capture begins and adds 37 modulo 144 each clock; a boundary is a wrap. Consecutive `tt_valid` pulses are therefore 3 or 4 cycles apart.
- R6: `tt_valid` is a one-cycle pulse per bit. `tt_bit` during that pulse equals `ttx_in` from the previous cycle, and `tt_bit` is 0 whenever `tt_valid` is 0.
- R7: An uncut window delivers exactly 360 pulses. `ttx_req` is 0 in the cycle the 360th pulse is visible.
- R8: If `hpos` equals `req_off_h` while `ttx_req` is 1, `ttx_req` falls in the next cycle. No further pulses follow, apart from a bit captured in that same cycle.
- R9: When the stop position coincides with the 360th bit boundary, the window still delivers 360 bits and the request falls exactly once.
- R10: On a line that is not selected, `ttx_req` and `tt_valid` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | One-cycle pulse at the start of each line |
| field_id | input | 1 | Current field, 0 = first, 1 = second |
| line_num | input | LINE_W | Line counter |
| hpos | input | HPOS_W | Horizontal position counter |
| f0_first | input | LINE_W | First text line, field 0 |
| f0_last | input | LINE_W | Last text line, field 0 |
| f1_first | input | LINE_W | First text line, field 1 |
| f1_last | input | LINE_W | Last text line, field 1 |
| req_on_h | input | HPOS_W | Horizontal position that opens the request |
| req_off_h | input | HPOS_W | Horizontal position that forces the request closed |
| lead_clks | input | LEAD_W | Clocks between request rise and start of capture, minus one |
| ttx_in | input | 1 | Serial teletext bit from the source |
| ttx_req | output | 1 | Request to the source to deliver bits |
| tt_valid | output | 1 | One-cycle strobe marking a captured bit |
| tt_bit | output | 1 | Captured bit, 0 outside a strobe |

## Verification
Two events can fall in the same cycle: the 360th bit boundary, which ends the window by count, and the stop position match, which ends it by position. The bench provokes this by placing `req_off_h` exactly `lead_clks` + 1403 positions after `req_on_h`. The window's last boundary then lands on the stop cycle. The result is judged by requiring 360 pulses, a single request fall in the cycle the last pulse shows, and no pulse afterwards. A separate case stops the window mid-stream and expects the pulse count that the accumulator formula gives at that point.

// File: rtl/ttx_pkg.sv
package ttx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LEAD = 2'd1,
      ST_RUN  = 2'd2
   } ttx_state_e;
endpackage

// File: rtl/ttx_line_sel.sv
module ttx_line_sel #(
   parameter int LINE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic              field_id,
   input  logic [LINE_W-1:0] line_num,
   input  logic [LINE_W-1:0] f0_first,
   input  logic [LINE_W-1:0] f0_last,
   input  logic [LINE_W-1:0] f1_first,
   input  logic [LINE_W-1:0] f1_last,
   output logic              line_en
);
   localparam int N_FIELDS = 2;

   logic [N_FIELDS-1:0][LINE_W-1:0] lo_q;
   logic [N_FIELDS-1:0][LINE_W-1:0] hi_q;
   logic [N_FIELDS-1:0]             in_rng;

   assign lo_q = {f1_first, f0_first};
   assign hi_q = {f1_last,  f0_last};

   for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
      assign in_rng[f] = (line_num >= lo_q[f]) && (line_num <= hi_q[f]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          line_en <= 1'b0;
      else if (line_start) line_en <= in_rng[field_id];
   end

   // R2: the selection only moves at a line start
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !line_start |=> $stable(line_en));
endmodule

// File: rtl/ttx_bit_seq.sv
module ttx_bit_seq #(
   parameter int ACC_MOD  = 144,
   parameter int ACC_INC  = 37,
   parameter int WIN_BITS = 360
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic ttx_in,
   output logic last_bit,
   output logic tt_valid,
   output logic tt_bit
);
   localparam int ACC_W = $clog2(ACC_MOD);
   localparam int SUM_W = ACC_W + 1;
   localparam int CNT_W = $clog2(WIN_BITS + 1);

   logic [ACC_W-1:0] acc;
   logic [SUM_W-1:0] acc_sum;
   logic [SUM_W-1:0] acc_wrap;
   logic [CNT_W-1:0] cnt;
   logic             bnd;

   assign acc_sum  = {1'b0, acc} + SUM_W'(ACC_INC);
   assign acc_wrap = acc_sum - SUM_W'(ACC_MOD);
   assign bnd      = run && (acc_sum >= SUM_W'(ACC_MOD));
   assign last_bit = bnd && (cnt == CNT_W'(WIN_BITS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
         cnt <= '0;
      end else if (!run) begin
         acc <= '0;
         cnt <= '0;
      end else if (bnd) begin
         acc <= acc_wrap[ACC_W-1:0];
         cnt <= cnt + 1'b1;
      end else begin
         acc <= acc_sum[ACC_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tt_valid <= 1'b0;
         tt_bit   <= 1'b0;
      end else begin
         tt_valid <= bnd;
         tt_bit   <= bnd & ttx_in;
      end
   end

   // R5: phase stays inside its modulus
   a_r5_acc_range: assert property (@(posedge clk) disable iff (!rst_n)
      acc < ACC_W'(ACC_MOD));
   // R5: a bit never lasts a single clock
   a_r5_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      tt_valid |=> !tt_valid);
   // R6: bit forced low between strobes
   a_r6_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !tt_valid |-> !tt_bit);
   // R7: count never exceeds the window
   a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(WIN_BITS));
endmodule

// File: rtl/ttx_inserter.sv
module ttx_inserter
   import ttx_pkg::*;
#(
   parameter int LINE_W   = 10,
   parameter int HPOS_W   = 11,
   parameter int LEAD_W   = 6,
   parameter int ACC_MOD  = 144,
   parameter int ACC_INC  = 37,
   parameter int WIN_BITS = 360
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic              field_id,
   input  logic [LINE_W-1:0] line_num,
   input  logic [HPOS_W-1:0] hpos,
   input  logic [LINE_W-1:0] f0_first,
   input  logic [LINE_W-1:0] f0_last,
   input  logic [LINE_W-1:0] f1_first,
   input  logic [LINE_W-1:0] f1_last,
   input  logic [HPOS_W-1:0] req_on_h,
   input  logic [HPOS_W-1:0] req_off_h,
   input  logic [LEAD_W-1:0] lead_clks,
   input  logic              ttx_in,
   output logic              ttx_req,
   output logic              tt_valid,
   output logic              tt_bit
);
   if (ACC_INC * 3 >= ACC_MOD || ACC_INC * 4 < ACC_MOD) begin : g_bad_rate
      $error("ttx_inserter: ACC_MOD/ACC_INC must lie in (3,4]");
   end
   if (WIN_BITS < 1) begin : g_bad_win
      $error("ttx_inserter: WIN_BITS must be positive");
   end

   ttx_state_e       state;
   logic [LEAD_W-1:0] lead_cnt;
   logic             line_en;
   logic             last_bit;
   logic             on_hit;
   logic             off_hit;
   logic             run;

   assign on_hit  = (hpos == req_on_h);
   assign off_hit = (hpos == req_off_h);
   assign run     = (state == ST_RUN);
   assign ttx_req = (state != ST_IDLE);

   ttx_line_sel #(.LINE_W(LINE_W)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_start(line_start),
      .field_id  (field_id),
      .line_num  (line_num),
      .f0_first  (f0_first),
      .f0_last   (f0_last),
      .f1_first  (f1_first),
      .f1_last   (f1_last),
      .line_en   (line_en)
   );

   ttx_bit_seq #(
      .ACC_MOD (ACC_MOD),
      .ACC_INC (ACC_INC),
      .WIN_BITS(WIN_BITS)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .ttx_in  (ttx_in),
      .last_bit(last_bit),
      .tt_valid(tt_valid),
      .tt_bit  (tt_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         lead_cnt <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (line_en && on_hit) begin
               state    <= ST_LEAD;
               lead_cnt <= lead_clks;
            end
            ST_LEAD: begin
               if (off_hit)              state <= ST_IDLE;
               else if (lead_cnt == '0)  state <= ST_RUN;
               else                      lead_cnt <= lead_cnt - 1'b1;
            end
            ST_RUN: if (last_bit || off_hit) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R3: request opens only at the programmed position on a selected line
   a_r3_rise_at_on: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ttx_req) |-> ($past(on_hit) && $past(line_en)));
   // R8: stop position closes the request
   a_r8_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (ttx_req && off_hit) |=> !ttx_req);
   // R7: last bit closes the request
   a_r7_close_on_last: assert property (@(posedge clk) disable iff (!rst_n)
      last_bit |=> !ttx_req);
   // R6: strobes only come out of an open window
   a_r6_valid_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      tt_valid |-> $past(ttx_req));
endmodule

// File: tb/ttx_inserter_bench.sv
`timescale 1ns/1ps
module ttx_inserter_bench;
   localparam int LW = 10, HW = 11, LDW = 6;
   localparam int MODV = 144, INCV = 37, WIN = 360, LINE_LEN = 1728;

   logic clk = 1'b0, rst_n = 1'b0, line_start = 1'b0, field_id = 1'b0, ttx_in = 1'b0;
   logic [LW-1:0]  line_num = '0, f0a = '0, f0b = '0, f1a = '0, f1b = '0;
   logic [HW-1:0]  hpos = '0, on_h = '0, off_h = '0;
   logic [LDW-1:0] lead = '0;
   wire ttx_req, tt_valid, tt_bit;

   int n_chk = 0, n_fail = 0, cyc = 0;
   int m_st = 0, m_lead = 0, m_j = 0, m_n = 0, t_on = 0, lead_at = 0;
   bit m_len = 0, e_req = 0, e_v = 0, e_b = 0;
   int nv_line = 0, prev_v = -1;

   always #2.5 clk = ~clk;

   ttx_inserter u_ttx_inserter (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .field_id(field_id),
      .line_num(line_num), .hpos(hpos), .f0_first(f0a), .f0_last(f0b),
      .f1_first(f1a), .f1_last(f1b), .req_on_h(on_h), .req_off_h(off_h),
      .lead_clks(lead), .ttx_in(ttx_in), .ttx_req(ttx_req),
      .tt_valid(tt_valid), .tt_bit(tt_bit));

   function automatic int bits_by(int j);
      return ((j + 1) * INCV) / MODV;
   endfunction

   function automatic bit is_bnd(int j);
      return bits_by(j) != (j * INCV) / MODV;
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic model_step();
      bit nv, nb;
      nv = 0; nb = 0;
      case (m_st)
         0: if (m_len && hpos == on_h) begin
               m_st = 1; m_lead = int'(lead); t_on = cyc; lead_at = int'(lead);
            end
         1: if (hpos == off_h) m_st = 0;
            else if (m_lead == 0) begin m_st = 2; m_j = 0; m_n = 0; end
            else m_lead--;
         default: begin
            if (is_bnd(m_j)) begin nv = 1; nb = ttx_in; m_n++; end
            if (m_n == WIN || hpos == off_h) m_st = 0;
            else m_j++;
         end
      endcase
      if (line_start)
         m_len = field_id ? (line_num >= f1a && line_num <= f1b)
                          : (line_num >= f0a && line_num <= f0b);
      e_req = (m_st != 0);
      e_v = nv;
      e_b = nv & nb;
   endtask

   task automatic compare();
      chk(ttx_req == e_req, "R3 R8 R10 request", int'(ttx_req), int'(e_req));
      chk(tt_valid == e_v, "R5 valid strobe", int'(tt_valid), int'(e_v));
      chk(tt_bit == e_b, "R6 captured bit", int'(tt_bit), int'(e_b));
      if (tt_valid) begin
         nv_line++;
         if (prev_v >= 0)
            chk((cyc - prev_v) == 3 || (cyc - prev_v) == 4, "R5 bit spacing",
                cyc - prev_v, 4);
         else
            chk(cyc - t_on == lead_at + 6, "R4 first bit latency",
                cyc - t_on, lead_at + 6);
         prev_v = cyc;
         if (nv_line == WIN)
            chk(!ttx_req, "R7 request low at last bit", int'(ttx_req), 0);
      end
   endtask

   task automatic run_line(int exp_bits, string tag);
      nv_line = 0;
      prev_v = -1;
      for (int h = 0; h < LINE_LEN; h++) begin
         @(negedge clk);
         cyc++;
         compare();
         line_start = (h == 0);
         hpos = HW'(h);
         ttx_in = 1'($urandom);
         model_step();
      end
      if (exp_bits >= 0) chk(nv_line == exp_bits, tag, nv_line, exp_bits);
   endtask

   task automatic set_line(int ln, bit fld);
      line_num = LW'(ln);
      field_id = fld;
   endtask

   initial begin
      #(200000 * 5);
      $display("FAIL watchdog expired");
      n_chk++;
      n_fail++;
      summary();
   end

   initial begin
      void'($urandom(32'd7182));
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(ttx_req == 0, "R1 request in reset", int'(ttx_req), 0);
      chk(tt_valid == 0, "R1 valid in reset", int'(tt_valid), 0);
      chk(tt_bit == 0, "R1 bit in reset", int'(tt_bit), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ttx_req == 0 && tt_valid == 0 && tt_bit == 0, "R1 after reset",
          int'({ttx_req, tt_valid, tt_bit}), 0);

      // field ranges, full windows, unselected lines
      f0a = 2; f0b = 3; f1a = 5; f1b = 6;
      on_h = 40; off_h = 0; lead = 5;
      set_line(1, 0); run_line(0,   "R10 line below field 0 range");
      set_line(2, 0); run_line(WIN, "R2 R7 field 0 first line");
      set_line(3, 0); run_line(WIN, "R2 R7 field 0 last line");
      set_line(4, 0); run_line(0,   "R10 line above field 0 range");
      set_line(5, 1); run_line(WIN, "R2 field 1 selected");
      set_line(7, 1); run_line(0,   "R10 field 1 beyond range");
      set_line(5, 0); run_line(0,   "R2 field 0 ignores field 1 range");

      // zero lead, request right after line start
      lead = 0; on_h = 1;
      set_line(2, 0); run_line(WIN, "R4 R7 zero lead");

      // stop position mid-window
      lead = 9; on_h = 30; off_h = 30 + 9 + 2 + 700;
      set_line(3, 0); run_line(bits_by(700), "R8 window cut by stop");

      // stop coincides with the 360th boundary
      lead = 5; on_h = 20; off_h = 20 + 5 + 1403;
      set_line(2, 0); run_line(WIN, "R9 stop on last bit");

      // stop during lead: no bits
      lead = 40; on_h = 50; off_h = 70;
      set_line(2, 0); run_line(0, "R8 stop during lead");

      // empty range
      f0a = 5; f0b = 2; off_h = 0; lead = 3;
      set_line(3, 0); run_line(0, "R2 first greater than last");

      // constrained random lines
      for (int r = 0; r < 8; r++) begin
         f0a = LW'($urandom_range(0, 6)); f0b = LW'($urandom_range(0, 10));
         f1a = LW'($urandom_range(0, 6)); f1b = LW'($urandom_range(0, 10));
         on_h = HW'($urandom_range(1, 200));
         lead = LDW'($urandom_range(0, 63));
         off_h = ($urandom_range(0, 1) == 1) ? HW'(0) : on_h + HW'($urandom_range(1, 1500));
         set_line(int'($urandom_range(0, 10)), 1'($urandom));
         run_line(-1, "");
      end

      @(negedge clk);
      cyc++;
      compare();
      summary();
   end
endmodule